// File: doc/BRIEF.md
# Inter-Processor Messaging Unit

This block passes messages between two bus masters, called the local side and the remote side. Each side has its own simple register port. There are three ways to send something. Message registers carry a single word, and writing one flags the receiving side. Doorbell registers carry bit flags that accumulate: the sender sets bits and the receiver clears them. Four internal circular queues, each 16 words deep, carry streams of words. Two queues carry data toward the local side and two toward the remote side.

The local side receives seven interrupt lines, each with its own enable bit. The remote side receives one interrupt line. It is the OR of five sources, and each source has its own enable bit. Each side reads a queue by reading that queue's address, which returns the head word and removes it. Each side writes a queue by writing that queue's address, which appends the word. A write to a full queue is dropped and sets a sticky overflow flag. A read from an empty queue returns all ones and changes nothing.

Top module: `msg_unit`

## Requirements
- R1: After reset, both interrupt outputs are low, every mask reads 0, and every status and doorbell register reads 0. The local raw-cause register at address 12 reads 0x20, because the outbound queues are not full.
- R2: A remote write to address 0 or 1 stores the word and sets local status bit 0 or 1 at address 10. The local side reads the word at the same address and clears the bit by writing a one to it. A local write to address 2 or 3 sets remote status bit 0 or 1 in the same way.
- R3: A write to the sender's doorbell address ORs the written bits into that doorbell. Address 4 is the inbound doorbell, written by the remote side. Address 5 is the outbound doorbell, written by the local side. The receiving side clears bits by writing ones to the same address.
- R4: Each side appends to a queue by writing its address and removes the head by reading it. Words come out in the order they went in, up to 16 words per queue. The remote side writes inbound queues 0 and 1 at addresses 6 and 7. The local side reads them at the same addresses. The local side writes outbound queues 0 and 1 at addresses 8 and 9. The remote side reads them at the same addresses.
- R5: A write to a full queue is dropped and leaves the queue contents unchanged. It sets a sticky overflow flag in local status bits [7:4], in the order inbound 0, inbound 1, outbound 0, outbound 1. The local side clears each flag by writing a one to it.
- R6: A read from an empty queue returns 0xFFFFFFFF and does not move the queue pointers.
- R7: Local interrupt bit i equals raw cause i ANDed with mask bit i. The mask is at address 11 and the raw causes are readable at address 12. The raw causes are: [0] inbound message 0 flagged, [1] inbound message 1 flagged, [2] inbound doorbell nonzero, [3] inbound queue 0 not empty, [4] inbound queue 1 not empty, [5] either outbound queue not full, [6] any overflow flag set.
- R8: The remote interrupt is the OR of five causes ANDed with the remote mask at address 11. The causes are: [0] and [1] outbound message flagged, [2] outbound doorbell nonzero, [3] outbound queue 0 not empty, [4] outbound queue 1 not empty.
- R9: When a bit is set and cleared in the same cycle, setting wins. This applies to message flags, doorbell bits and overflow flags. In a doorbell, bits that are only cleared are still cleared.
- R10: When a queue is pushed and popped in the same cycle, the pop returns the old head. If the queue was not full, the pushed word is kept. If the queue was full, the pushed word is dropped and the overflow flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_cs_i | input | 1 | Local access strobe |
| l_we_i | input | 1 | Local write (1) or read (0) |
| l_addr_i | input | 4 | Local register address |
| l_wdata_i | input | 32 | Local write data |
| l_rdata_o | output | 32 | Local read data, valid in the same cycle as the strobe |
| r_cs_i | input | 1 | Remote access strobe |
| r_we_i | input | 1 | Remote write (1) or read (0) |
| r_addr_i | input | 4 | Remote register address |
| r_wdata_i | input | 32 | Remote write data |
| r_rdata_o | output | 32 | Remote read data, valid in the same cycle as the strobe |
| l_irq_o | output | 7 | Masked local interrupts |
| r_irq_o | output | 1 | Combined masked remote interrupt |

## Verification
The two ports are independent, so one side can set a flag while the other clears it in the same cycle. One side can also push a queue while the other pops it. The bench drives both ports in a single cycle to create these collisions. One case is a message write against a write-one-to-clear of its flag. Another is a doorbell set against a clear of the same bit and of a different bit. The remaining cases push and pop one queue together, once when it holds a single word and once when it is full. Each outcome is judged afterwards through normal reads: the flag value, the doorbell contents, and the full sequence drained from the queue together with its overflow flag.

// File: rtl/mu_pkg.sv
package mu_pkg;
  localparam int AW       = 4;
  localparam int N_LIRQ   = 7;
  localparam int N_RIRQ   = 5;

  localparam logic [AW-1:0] A_MSG_IN0  = 4'd0;
  localparam logic [AW-1:0] A_MSG_IN1  = 4'd1;
  localparam logic [AW-1:0] A_MSG_OUT0 = 4'd2;
  localparam logic [AW-1:0] A_MSG_OUT1 = 4'd3;
  localparam logic [AW-1:0] A_BELL_IN  = 4'd4;
  localparam logic [AW-1:0] A_BELL_OUT = 4'd5;
  localparam logic [AW-1:0] A_Q_IN0    = 4'd6;
  localparam logic [AW-1:0] A_Q_IN1    = 4'd7;
  localparam logic [AW-1:0] A_Q_OUT0   = 4'd8;
  localparam logic [AW-1:0] A_Q_OUT1   = 4'd9;
  localparam logic [AW-1:0] A_STAT     = 4'd10;
  localparam logic [AW-1:0] A_MASK     = 4'd11;
  localparam logic [AW-1:0] A_RAW      = 4'd12;
endpackage

// File: rtl/mu_flags.sv
// Sticky bit register: set vector wins over clear vector.
module mu_flags #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] bits_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bits_o <= '0;
    else         bits_o <= (bits_o & ~clr_i) | set_i;
  end

  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((bits_o & $past(set_i)) == $past(set_i)));

  p_clear_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((bits_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/mu_fifo.sv
module mu_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          drop_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CW'(DEPTH));
  assign do_push = push_i & ~full_o;   // full check ignores a same-cycle pop
  assign do_pop  = pop_i & ~empty_o;
  assign drop_o  = push_i & full_o;
  assign rdata_o = empty_o ? '1 : mem[rp];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> (full_o && $stable(wp)));

  p_empty_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> (empty_o && $stable(rp)));

  p_count_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(DEPTH));
endmodule

// File: rtl/msg_unit.sv
module msg_unit
  import mu_pkg::*;
#(
  parameter int DW     = 32,
  parameter int QDEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_cs_i,
  input  logic              l_we_i,
  input  logic [AW-1:0]     l_addr_i,
  input  logic [DW-1:0]     l_wdata_i,
  output logic [DW-1:0]     l_rdata_o,
  input  logic              r_cs_i,
  input  logic              r_we_i,
  input  logic [AW-1:0]     r_addr_i,
  input  logic [DW-1:0]     r_wdata_i,
  output logic [DW-1:0]     r_rdata_o,
  output logic [N_LIRQ-1:0] l_irq_o,
  output logic              r_irq_o
);
  localparam int NQ = 4;

  logic l_wr, l_rd, r_wr, r_rd;
  assign l_wr = l_cs_i &  l_we_i;
  assign l_rd = l_cs_i & ~l_we_i;
  assign r_wr = r_cs_i &  r_we_i;
  assign r_rd = r_cs_i & ~r_we_i;

  // message words
  logic [DW-1:0] msg_in [2];
  logic [DW-1:0] msg_out[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_in[0]  <= '0;
      msg_in[1]  <= '0;
      msg_out[0] <= '0;
      msg_out[1] <= '0;
    end else begin
      if (r_wr && r_addr_i == A_MSG_IN0)  msg_in[0]  <= r_wdata_i;
      if (r_wr && r_addr_i == A_MSG_IN1)  msg_in[1]  <= r_wdata_i;
      if (l_wr && l_addr_i == A_MSG_OUT0) msg_out[0] <= l_wdata_i;
      if (l_wr && l_addr_i == A_MSG_OUT1) msg_out[1] <= l_wdata_i;
    end
  end

  // masks
  logic [N_LIRQ-1:0] l_mask;
  logic [N_RIRQ-1:0] r_mask;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_mask <= '0;
      r_mask <= '0;
    end else begin
      if (l_wr && l_addr_i == A_MASK) l_mask <= l_wdata_i[N_LIRQ-1:0];
      if (r_wr && r_addr_i == A_MASK) r_mask <= r_wdata_i[N_RIRQ-1:0];
    end
  end

  // flag registers
  logic [1:0]    mst_in, mst_out;
  logic [DW-1:0] bell_in, bell_out;
  logic [NQ-1:0] ovf, q_drop;
  logic          l_stat_wr, r_stat_wr;
  assign l_stat_wr = l_wr && l_addr_i == A_STAT;
  assign r_stat_wr = r_wr && r_addr_i == A_STAT;

  mu_flags #(.W(2)) u_mst_in (
    .clk_i, .rst_ni,
    .set_i  ({r_wr && r_addr_i == A_MSG_IN1, r_wr && r_addr_i == A_MSG_IN0}),
    .clr_i  (l_stat_wr ? l_wdata_i[1:0] : 2'b00),
    .bits_o (mst_in)
  );

  mu_flags #(.W(2)) u_mst_out (
    .clk_i, .rst_ni,
    .set_i  ({l_wr && l_addr_i == A_MSG_OUT1, l_wr && l_addr_i == A_MSG_OUT0}),
    .clr_i  (r_stat_wr ? r_wdata_i[1:0] : 2'b00),
    .bits_o (mst_out)
  );

  mu_flags #(.W(DW)) u_bell_in (
    .clk_i, .rst_ni,
    .set_i  ((r_wr && r_addr_i == A_BELL_IN) ? r_wdata_i : '0),
    .clr_i  ((l_wr && l_addr_i == A_BELL_IN) ? l_wdata_i : '0),
    .bits_o (bell_in)
  );

  mu_flags #(.W(DW)) u_bell_out (
    .clk_i, .rst_ni,
    .set_i  ((l_wr && l_addr_i == A_BELL_OUT) ? l_wdata_i : '0),
    .clr_i  ((r_wr && r_addr_i == A_BELL_OUT) ? r_wdata_i : '0),
    .bits_o (bell_out)
  );

  mu_flags #(.W(NQ)) u_ovf (
    .clk_i, .rst_ni,
    .set_i  (q_drop),
    .clr_i  (l_stat_wr ? l_wdata_i[7:4] : 4'h0),
    .bits_o (ovf)
  );

  // queues: 0,1 inbound (remote -> local), 2,3 outbound (local -> remote)
  logic [NQ-1:0] q_push, q_pop, q_empty, q_full;
  logic [DW-1:0] q_wd [NQ];
  logic [DW-1:0] q_rd [NQ];

  always_comb begin
    q_push[0] = r_wr && r_addr_i == A_Q_IN0;
    q_push[1] = r_wr && r_addr_i == A_Q_IN1;
    q_push[2] = l_wr && l_addr_i == A_Q_OUT0;
    q_push[3] = l_wr && l_addr_i == A_Q_OUT1;
    q_pop[0]  = l_rd && l_addr_i == A_Q_IN0;
    q_pop[1]  = l_rd && l_addr_i == A_Q_IN1;
    q_pop[2]  = r_rd && r_addr_i == A_Q_OUT0;
    q_pop[3]  = r_rd && r_addr_i == A_Q_OUT1;
    q_wd[0]   = r_wdata_i;
    q_wd[1]   = r_wdata_i;
    q_wd[2]   = l_wdata_i;
    q_wd[3]   = l_wdata_i;
  end

  for (genvar g = 0; g < NQ; g++) begin : g_q
    mu_fifo #(.DW(DW), .DEPTH(QDEPTH)) u_fifo (
      .clk_i, .rst_ni,
      .push_i  (q_push[g]),
      .pop_i   (q_pop[g]),
      .wdata_i (q_wd[g]),
      .rdata_o (q_rd[g]),
      .empty_o (q_empty[g]),
      .full_o  (q_full[g]),
      .drop_o  (q_drop[g])
    );
  end

  // interrupts
  logic [N_LIRQ-1:0] l_raw;
  logic [N_RIRQ-1:0] r_raw;
  assign l_raw = {|ovf, ~(q_full[2] & q_full[3]), ~q_empty[1], ~q_empty[0],
                  |bell_in, mst_in};
  assign r_raw = {~q_empty[3], ~q_empty[2], |bell_out, mst_out};
  assign l_irq_o = l_raw & l_mask;
  assign r_irq_o = |(r_raw & r_mask);

  // read muxes
  always_comb begin
    l_rdata_o = '0;
    if (l_rd) begin
      case (l_addr_i)
        A_MSG_IN0:  l_rdata_o = msg_in[0];
        A_MSG_IN1:  l_rdata_o = msg_in[1];
        A_MSG_OUT0: l_rdata_o = msg_out[0];
        A_MSG_OUT1: l_rdata_o = msg_out[1];
        A_BELL_IN:  l_rdata_o = bell_in;
        A_BELL_OUT: l_rdata_o = bell_out;
        A_Q_IN0:    l_rdata_o = q_rd[0];
        A_Q_IN1:    l_rdata_o = q_rd[1];
        A_STAT:     l_rdata_o = DW'({ovf, 2'b00, mst_in});
        A_MASK:     l_rdata_o = DW'(l_mask);
        A_RAW:      l_rdata_o = DW'(l_raw);
        default:    l_rdata_o = '0;
      endcase
    end
  end

  always_comb begin
    r_rdata_o = '0;
    if (r_rd) begin
      case (r_addr_i)
        A_MSG_IN0:  r_rdata_o = msg_in[0];
        A_MSG_IN1:  r_rdata_o = msg_in[1];
        A_MSG_OUT0: r_rdata_o = msg_out[0];
        A_MSG_OUT1: r_rdata_o = msg_out[1];
        A_BELL_IN:  r_rdata_o = bell_in;
        A_BELL_OUT: r_rdata_o = bell_out;
        A_Q_OUT0:   r_rdata_o = q_rd[2];
        A_Q_OUT1:   r_rdata_o = q_rd[3];
        A_STAT:     r_rdata_o = DW'(mst_out);
        A_MASK:     r_rdata_o = DW'(r_mask);
        A_RAW:      r_rdata_o = DW'(r_raw);
        default:    r_rdata_o = '0;
      endcase
    end
  end

  p_msg_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_wr && r_addr_i == A_MSG_IN0) |=> (mst_in[0] && msg_in[0] == $past(r_wdata_i)));

  p_empty_ones_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_rd && l_addr_i == A_Q_IN0 && q_empty[0]) |-> (l_rdata_o == '1));

  p_ovf_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf[0] && !(l_stat_wr && l_wdata_i[4])) |=> ovf[0]);

  p_drop_flags_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_full[1] && q_push[1]) |=> ovf[1]);
endmodule

// File: tb/sim_msg_unit.sv
module sim_msg_unit;
  import mu_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        l_cs = 0, l_we = 0, r_cs = 0, r_we = 0;
  logic [3:0]  l_addr = '0, r_addr = '0;
  logic [31:0] l_wd = '0, r_wd = '0;
  logic [31:0] l_rdata, r_rdata;
  logic [6:0]  l_irq;
  logic        r_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  msg_unit u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .l_cs_i(l_cs), .l_we_i(l_we), .l_addr_i(l_addr), .l_wdata_i(l_wd), .l_rdata_o(l_rdata),
    .r_cs_i(r_cs), .r_we_i(r_we), .r_addr_i(r_addr), .r_wdata_i(r_wd), .r_rdata_o(r_rdata),
    .l_irq_o(l_irq), .r_irq_o(r_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // one bus cycle on both sides; read data captured before the edge
  task automatic cyc(input logic lc, input logic lw, input logic [3:0] la, input logic [31:0] ld,
                     input logic rc, input logic rw, input logic [3:0] ra, input logic [31:0] rd,
                     output logic [31:0] lq, output logic [31:0] rq);
    @(negedge clk);
    l_cs = lc; l_we = lw; l_addr = la; l_wd = ld;
    r_cs = rc; r_we = rw; r_addr = ra; r_wd = rd;
    #1;
    lq = l_rdata; rq = r_rdata;
    @(posedge clk); #1;
    l_cs = 0; r_cs = 0;
  endtask

  task automatic lwr(input logic [3:0] a, input logic [31:0] d);
    logic [31:0] x, y;
    cyc(1, 1, a, d, 0, 0, 4'd0, '0, x, y);
  endtask
  task automatic rwr(input logic [3:0] a, input logic [31:0] d);
    logic [31:0] x, y;
    cyc(0, 0, 4'd0, '0, 1, 1, a, d, x, y);
  endtask
  task automatic lrd(input logic [3:0] a, output logic [31:0] q);
    logic [31:0] y;
    cyc(1, 0, a, '0, 0, 0, 4'd0, '0, q, y);
  endtask
  task automatic rrd(input logic [3:0] a, output logic [31:0] q);
    logic [31:0] x;
    cyc(0, 0, 4'd0, '0, 1, 0, a, '0, x, q);
  endtask

  function automatic logic [31:0] pat(input int q, input int i);
    return (32'(i) * 32'h01010101) ^ (32'(q) << 28) ^ 32'h0000_5A00;
  endfunction

  initial begin : watchdog
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] q, acc, lq, rq;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: reset state
    chk("R1 l_irq", 32'(l_irq), 0);
    chk("R1 r_irq", 32'(r_irq), 0);
    lrd(A_MASK, q);  chk("R1 l_mask", q, 0);
    rrd(A_MASK, q);  chk("R1 r_mask", q, 0);
    lrd(A_STAT, q);  chk("R1 l_stat", q, 0);
    rrd(A_STAT, q);  chk("R1 r_stat", q, 0);
    lrd(A_BELL_IN, q); chk("R1 bell_in", q, 0);
    lrd(A_RAW, q);   chk("R1 l_raw", q, 32'h20);

    lwr(A_MASK, 32'h7F);
    rwr(A_MASK, 32'h1F);
    chk("R7 mask idle", 32'(l_irq), 32'h20);
    chk("R8 idle", 32'(r_irq), 0);

    // R2: message registers
    for (int m = 0; m < 2; m++) begin
      rwr(4'(A_MSG_IN0 + 4'(m)), 32'hC0DE_0000 + 32'(m));
      lrd(4'(A_MSG_IN0 + 4'(m)), q);
      chk("R2 msg_in data", q, 32'hC0DE_0000 + 32'(m));
      lrd(A_STAT, q); chk("R2 msg_in flag", q, 32'(1 << m));
      chk("R7 msg irq", 32'(l_irq), 32'h20 | 32'(1 << m));
      lwr(A_STAT, 32'(1 << m));
      lrd(A_STAT, q); chk("R2 msg_in w1c", q, 0);
      chk("R7 msg irq clr", 32'(l_irq), 32'h20);
      lwr(4'(A_MSG_OUT0 + 4'(m)), 32'hBEEF_0010 + 32'(m));
      rrd(4'(A_MSG_OUT0 + 4'(m)), q);
      chk("R2 msg_out data", q, 32'hBEEF_0010 + 32'(m));
      rrd(A_STAT, q); chk("R2 msg_out flag", q, 32'(1 << m));
      chk("R8 msg irq", 32'(r_irq), 1);
      rwr(A_STAT, 32'(1 << m));
      chk("R8 msg irq clr", 32'(r_irq), 0);
    end

    // R3: inbound doorbell sweep, set then clear each bit
    acc = 0;
    for (int b = 0; b < 32; b++) begin
      rwr(A_BELL_IN, 32'h1 << b);
      acc |= 32'h1 << b;
      lrd(A_BELL_IN, q); chk("R3 bell set", q, acc);
    end
    for (int b = 0; b < 32; b++) begin
      lwr(A_BELL_IN, 32'h1 << b);
      acc &= ~(32'h1 << b);
      lrd(A_BELL_IN, q); chk("R3 bell clr", q, acc);
      chk("R7 bell irq", 32'(l_irq[2]), 32'(acc != 0));
    end
    lwr(A_BELL_OUT, 32'hA5A5_0000);
    lwr(A_BELL_OUT, 32'h0000_00F0);
    rrd(A_BELL_OUT, q); chk("R3 bell_out or", q, 32'hA5A5_00F0);
    chk("R8 bell irq", 32'(r_irq), 1);
    rwr(A_BELL_OUT, 32'hA5A5_0010);
    rrd(A_BELL_OUT, q); chk("R3 bell_out clr", q, 32'h0000_00E0);
    rwr(A_BELL_OUT, 32'hFFFF_FFFF);
    chk("R8 bell irq clr", 32'(r_irq), 0);

    // R4: inbound queues, fill and drain in order
    for (int qq = 0; qq < 2; qq++) begin
      for (int i = 0; i < 16; i++) rwr(4'(A_Q_IN0 + 4'(qq)), pat(qq, i));
      chk("R7 iq irq", 32'(l_irq[3 + qq]), 1);
    end
    for (int qq = 0; qq < 2; qq++) begin
      for (int i = 0; i < 16; i++) begin
        lrd(4'(A_Q_IN0 + 4'(qq)), q); chk("R4 iq order", q, pat(qq, i));
      end
      chk("R7 iq irq drained", 32'(l_irq[3 + qq]), 0);
    end

    // R4/R5/R7: outbound queues, overflow on the 17th word
    for (int i = 0; i < 16; i++) lwr(A_Q_OUT0, pat(2, i));
    chk("R7 oq free one full", 32'(l_irq[5]), 1);
    for (int i = 0; i < 16; i++) lwr(A_Q_OUT1, pat(3, i));
    chk("R7 oq free both full", 32'(l_irq[5]), 0);
    lwr(A_Q_OUT1, 32'hDEAD_DEAD);
    lrd(A_STAT, q); chk("R5 ovf flag", q, 32'h80);
    chk("R7 ovf irq", 32'(l_irq[6]), 1);
    rwr(A_MASK, 32'h08);
    chk("R8 oq irq", 32'(r_irq), 1);
    for (int i = 0; i < 16; i++) begin
      rrd(A_Q_OUT0, q); chk("R4 oq0 order", q, pat(2, i));
    end
    chk("R8 oq irq drained", 32'(r_irq), 0);
    for (int i = 0; i < 16; i++) begin
      rrd(A_Q_OUT1, q); chk("R5 oq1 intact", q, pat(3, i));
    end
    lwr(A_STAT, 32'h80);
    lrd(A_STAT, q); chk("R5 ovf w1c", q, 0);

    // R6: empty reads
    rrd(A_Q_OUT1, q); chk("R6 empty oq", q, 32'hFFFF_FFFF);
    lrd(A_Q_IN0, q);  chk("R6 empty iq", q, 32'hFFFF_FFFF);
    lrd(A_Q_IN0, q);  chk("R6 empty iq again", q, 32'hFFFF_FFFF);
    rwr(A_Q_IN0, 32'h1234_5678);
    lrd(A_Q_IN0, q);  chk("R6 pointers held", q, 32'h1234_5678);
    lrd(A_Q_IN0, q);  chk("R6 empty after", q, 32'hFFFF_FFFF);

    // R9: same-cycle set and clear
    rwr(A_MSG_IN0, 32'h1);
    cyc(1, 1, A_STAT, 32'h1, 1, 1, A_MSG_IN0, 32'h2, lq, rq);
    lrd(A_STAT, q); chk("R9 msg set wins", q, 32'h1);
    lwr(A_STAT, 32'h1);
    rwr(A_BELL_IN, 32'h10);
    cyc(1, 1, A_BELL_IN, 32'h18, 1, 1, A_BELL_IN, 32'h28, lq, rq);
    lrd(A_BELL_IN, q); chk("R9 bell collide", q, 32'h28);
    lwr(A_BELL_IN, 32'hFFFF_FFFF);

    // R10: push and pop together, partial and full
    rwr(A_Q_IN0, 32'hAAAA_0001);
    cyc(1, 0, A_Q_IN0, '0, 1, 1, A_Q_IN0, 32'hAAAA_0002, lq, rq);
    chk("R10 pop old head", lq, 32'hAAAA_0001);
    lrd(A_Q_IN0, q); chk("R10 push kept", q, 32'hAAAA_0002);
    lrd(A_Q_IN0, q); chk("R10 then empty", q, 32'hFFFF_FFFF);
    for (int i = 0; i < 16; i++) rwr(A_Q_IN1, pat(1, i));
    cyc(1, 0, A_Q_IN1, '0, 1, 1, A_Q_IN1, 32'hBAD0_BAD0, lq, rq);
    chk("R10 full pop head", lq, pat(1, 0));
    lrd(A_STAT, q); chk("R10 full drop flag", q, 32'h20);
    for (int i = 1; i < 16; i++) begin
      lrd(A_Q_IN1, q); chk("R10 full drain", q, pat(1, i));
    end
    lrd(A_Q_IN1, q); chk("R10 dropped word absent", q, 32'hFFFF_FFFF);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule